// File: doc/BRIEF.md
# AES-128 Block Cipher Engine with Self-Updating Key Store

The engine runs AES-128 on one 128-bit block at a time and sits behind a narrow byte-wide register port. Software, or a DMA channel, fills a 16-byte block memory and a 16-byte key memory one byte per access. It then writes the control register to pick a direction and launch the run. Eleven clock cycles later the result replaces the input in the block memory. A one-cycle completion strobe marks the end of the run and can serve directly as a DMA request.

The round key is never kept in a separate copy. The key memory itself steps through the key schedule, forwards during encryption and backwards during decryption. After encrypting, the key memory holds the tenth round key, which is exactly the key that decryption expects as input. After decrypting, it holds the original cipher key again. Software can therefore derive a decryption key by encrypting any block with the cipher key and reading the key memory back.

Top module: `aes_core`

## Requirements
- R1: After reset, the status register reads 0 (done and busy clear) and the completion strobe `done_evt` is low.
- R2: Each write or read of the block register (address 2) moves that access's own pointer on by one byte. The pointer wraps from byte 15 to byte 0, so a 17th write overwrites byte 0.
- R3: The key register (address 3) has a write pointer and a read pointer that are independent of each other. Reading keys off the read pointer only, whatever the write pointer holds.
- R4: Any read or write of the control register (address 0) returns all four byte pointers to 0.
- R5: While idle, reading the key memory returns exactly the bytes written. The key memory changes only through key-register writes or a run.
- R6: A start (control write with bit 0 = 1 while idle) with bit 1 = 0 encrypts. `done_evt` pulses exactly 11 cycles after the start write, and the block memory then holds the AES-128 ciphertext of the loaded plaintext (byte 0 is the first byte of the block).
- R7: After an encryption run, the key memory holds the final (tenth) round key of the loaded cipher key.
- R8: A start with bit 1 = 1 decrypts. This requires the tenth round key to have been loaded. The block memory ends up holding the plaintext and the key memory ends up holding the original cipher key.
- R9: `busy` is high from the cycle after the start write up to the cycle in which `done_evt` is high. `done_evt` lasts exactly one cycle.
- R10: While busy, writes to the block and key registers are ignored, and so are their pointer advances.
- R11: Status bit 0 (done) is set when a run finishes. It is cleared by a new start or by a status write with bit 0 = 1, and a status write with bit 0 = 0 leaves it set.
- R12: The status register (address 1) reads {busy, done} in bits 1:0. The control register reads the selected direction in bit 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 2 | Register select: 0 control, 1 status, 2 block data, 3 key |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; advances block/key read pointers, clears pointers on control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| busy | output | 1 | A run is in progress |
| done_evt | output | 1 | One-cycle completion strobe, usable as DMA request |

## Verification
The hardest situation to reach from the ports is a decryption that starts from a key memory that a previous encryption left behind. This exercises the backward key schedule against a forward schedule that the design itself produced. The bench reaches it by encrypting a random block and then, without touching the memories, issuing a decrypt start. It expects the original plaintext and cipher key back. Writes aimed at the memories in the middle of a run are also placed deliberately within the eleven busy cycles.

// File: rtl/aes_core_pkg.sv
package aes_core_pkg;

  localparam int BLK_BYTES  = 16;
  localparam int BLK_W      = 8 * BLK_BYTES;
  localparam int PTR_W      = $clog2(BLK_BYTES);
  localparam int NUM_ROUNDS = 10;
  localparam int RND_W      = $clog2(NUM_ROUNDS + 2);

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_KEY  = 2'd3
  } reg_sel_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254 (maps 0 to 0)
  function automatic logic [7:0] gf_inv(input logic [7:0] x);
    logic [7:0] p;
    p = x;
    for (int i = 0; i < 6; i++) p = gf_mul(gf_mul(p, p), x);
    return gf_mul(p, p);
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] b;
    b = gf_inv(x);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sbox(input logic [7:0] s);
    return gf_inv(rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05);
  endfunction

  function automatic logic [31:0] sub_rot(input logic [31:0] w);
    return {sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0]), sbox(w[31:24])};
  endfunction

  function automatic logic [7:0] rcon_of(input logic [RND_W-1:0] n);
    logic [7:0] r;
    r = 8'h01;
    for (int j = 1; j < NUM_ROUNDS; j++) if (j < int'(n)) r = xtime(r);
    return r;
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09),
            gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d),
            gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b),
            gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e)};
  endfunction

endpackage

// File: rtl/aes_keystep.sv
module aes_keystep
  import aes_core_pkg::*;
(
  input  logic [BLK_W-1:0] key_i,
  input  logic [7:0]       rcon_i,
  input  logic             backward_i,
  output logic [BLK_W-1:0] key_o
);
  logic [31:0] w0, w1, w2, w3;
  logic [31:0] f0, f1, f2, f3;
  logic [31:0] b0, b1, b2, b3;

  assign {w0, w1, w2, w3} = key_i;

  // forward schedule step
  assign f0 = w0 ^ sub_rot(w3) ^ {rcon_i, 24'h0};
  assign f1 = w1 ^ f0;
  assign f2 = w2 ^ f1;
  assign f3 = w3 ^ f2;

  // backward schedule step
  assign b3 = w3 ^ w2;
  assign b2 = w2 ^ w1;
  assign b1 = w1 ^ w0;
  assign b0 = w0 ^ sub_rot(b3) ^ {rcon_i, 24'h0};

  assign key_o = backward_i ? {b0, b1, b2, b3} : {f0, f1, f2, f3};
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_core_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             decrypt_i,
  input  logic             init_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] state_o
);
  logic [7:0]       ib [BLK_BYTES];
  logic [7:0]       kb [BLK_BYTES];
  logic [7:0]       fsr[BLK_BYTES];
  logic [7:0]       dsr[BLK_BYTES];
  logic [BLK_W-1:0] enc_v, dec_v;

  for (genvar b = 0; b < BLK_BYTES; b++) begin : g_byte
    assign ib[b] = state_i[8*(BLK_BYTES-1-b) +: 8];
    assign kb[b] = rkey_i[8*(BLK_BYTES-1-b) +: 8];
  end

  for (genvar c = 0; c < 4; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign fsr[c*4+r] = sbox(ib[((c + r) % 4)*4 + r]);
      assign dsr[c*4+r] = inv_sbox(ib[((c + 4 - r) % 4)*4 + r]) ^ kb[c*4+r];
    end
    localparam int HI = BLK_W - 1 - 32*c;
    logic [31:0] fcol, dcol;
    assign fcol = {fsr[c*4], fsr[c*4+1], fsr[c*4+2], fsr[c*4+3]};
    assign dcol = {dsr[c*4], dsr[c*4+1], dsr[c*4+2], dsr[c*4+3]};
    assign enc_v[HI -: 32] = (last_i ? fcol : mix_col(fcol)) ^ rkey_i[HI -: 32];
    assign dec_v[HI -: 32] = last_i ? dcol : inv_mix_col(dcol);
  end

  always_comb begin
    if (init_i)         state_o = state_i ^ rkey_i;
    else if (decrypt_i) state_o = dec_v;
    else                state_o = enc_v;
  end
endmodule

// File: rtl/aes_seq.sv
module aes_seq
  import aes_core_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clr_done_i,
  output logic             busy_o,
  output logic [RND_W-1:0] rnd_o,
  output logic             done_evt_o,
  output logic             done_flag_o
);
  logic             busy_q, busy_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic             evt_q, evt_d;
  logic             flag_q, flag_d;
  logic             accept;

  assign accept = start_i && !busy_q;

  always_comb begin
    busy_d = busy_q;
    rnd_d  = rnd_q;
    evt_d  = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      rnd_d  = '0;
    end else if (busy_q) begin
      if (rnd_q == RND_W'(NUM_ROUNDS)) begin
        busy_d = 1'b0;
        evt_d  = 1'b1;
      end else begin
        rnd_d = rnd_q + 1'b1;
      end
    end
    flag_d = flag_q;
    if (evt_d)                    flag_d = 1'b1;
    else if (accept || clr_done_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rnd_q  <= '0;
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rnd_q  <= rnd_d;
      evt_q  <= evt_d;
      flag_q <= flag_d;
    end
  end

  assign busy_o      = busy_q;
  assign rnd_o       = rnd_q;
  assign done_evt_o  = evt_q;
  assign done_flag_o = flag_q;

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_i)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |=> !evt_q); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> ($past(busy_q) && $past(rnd_q) == RND_W'(NUM_ROUNDS) && !busy_q)); // R6
  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> flag_q); // R11
endmodule

// File: rtl/aes_core.sv
module aes_core
  import aes_core_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       busy,
  output logic       done_evt
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  reg_sel_e         sel;
  logic             ctrl_acc, data_wr, data_rd, key_wr, key_rd, start, clr_done;
  logic             busy_w, done_flag;
  logic [RND_W-1:0] rnd;
  logic [RND_W-1:0] rc_idx;
  logic [BLK_W-1:0] st_q, st_d, key_q, key_d, ks_out, rkey, rnd_out;
  logic [PTR_W-1:0] dwp_q, dwp_d, drp_q, drp_d, kwp_q, kwp_d, krp_q, krp_d;
  logic             mode_q, mode_d;

  assign sel      = reg_sel_e'(addr);
  assign ctrl_acc = (wr_en || rd_en) && sel == REG_CTRL;
  assign data_wr  = wr_en && sel == REG_DATA && !busy_w;
  assign key_wr   = wr_en && sel == REG_KEY && !busy_w;
  assign data_rd  = rd_en && sel == REG_DATA;
  assign key_rd   = rd_en && sel == REG_KEY;
  assign start    = wr_en && sel == REG_CTRL && wdata[0];
  assign clr_done = wr_en && sel == REG_STAT && wdata[0];

  aes_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .clr_done_i (clr_done),
    .busy_o     (busy_w),
    .rnd_o      (rnd),
    .done_evt_o (done_evt),
    .done_flag_o(done_flag)
  );

  assign rc_idx = mode_q ? (RND_W'(NUM_ROUNDS + 1) - rnd) : rnd;

  aes_keystep u_key (
    .key_i     (key_q),
    .rcon_i    (rcon_of(rc_idx)),
    .backward_i(mode_q),
    .key_o     (ks_out)
  );

  assign rkey = (rnd == '0) ? key_q : ks_out;

  aes_round u_round (
    .state_i  (st_q),
    .rkey_i   (rkey),
    .decrypt_i(mode_q),
    .init_i   (rnd == '0),
    .last_i   (rnd == RND_W'(NUM_ROUNDS)),
    .state_o  (rnd_out)
  );

  always_comb begin
    st_d   = st_q;
    key_d  = key_q;
    dwp_d  = dwp_q;
    drp_d  = drp_q;
    kwp_d  = kwp_q;
    krp_d  = krp_q;
    mode_d = mode_q;
    if (ctrl_acc) begin
      dwp_d = '0;
      drp_d = '0;
      kwp_d = '0;
      krp_d = '0;
      if (wr_en && !busy_w) mode_d = wdata[1];
    end
    if (data_wr) begin
      st_d[{~dwp_q, 3'b000} +: 8] = wdata;
      dwp_d = dwp_q + 1'b1;
    end
    if (key_wr) begin
      key_d[{~kwp_q, 3'b000} +: 8] = wdata;
      kwp_d = kwp_q + 1'b1;
    end
    if (data_rd) drp_d = drp_q + 1'b1;
    if (key_rd)  krp_d = krp_q + 1'b1;
    if (busy_w) begin
      st_d  = rnd_out;
      key_d = rkey;
    end
  end

  // memories carry no reset
  always_ff @(posedge clk) begin
    st_q  <= st_d;
    key_q <= key_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwp_q  <= '0;
      drp_q  <= '0;
      kwp_q  <= '0;
      krp_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      dwp_q  <= dwp_d;
      drp_q  <= drp_d;
      kwp_q  <= kwp_d;
      krp_q  <= krp_d;
      mode_q <= mode_d;
    end
  end

  always_comb begin
    unique case (sel)
      REG_CTRL: rdata = {6'b0, mode_q, 1'b0};
      REG_STAT: rdata = {6'b0, busy_w, done_flag};
      REG_DATA: rdata = st_q[{~drp_q, 3'b000} +: 8];
      default:  rdata = key_q[{~krp_q, 3'b000} +: 8];
    endcase
  end

  assign busy = busy_w;

  AST_CTRL_CLEARS_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc |=> (dwp_q == '0 && drp_q == '0 && kwp_q == '0 && krp_q == '0)); // R4
  AST_WR_PTRS_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && !ctrl_acc) |=> ($stable(dwp_q) && $stable(kwp_q))); // R10
  AST_KEY_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !(wr_en && sel == REG_KEY)) |=> $stable(key_q)); // R5
  AST_MODE_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(mode_q)); // R8
endmodule

// File: tb/aes_core_tb.sv
module aes_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_KEY = 2'd3;

  logic       clk, rst_ni, wr_en, rd_en, busy, done_evt;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  int         n_tests, n_fail;
  logic [7:0] ref_sb[256];

  aes_core u_dut (
    .clk(clk), .rst_ni(rst_ni), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .busy(busy), .done_evt(done_evt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p;
    p = 16'h0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011b << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] m_xt(input logic [7:0] a);
    return m_mul(a, 8'h02);
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv, s;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (m_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
      ref_sb[x] = s;
    end
  endtask

  function automatic void ref_enc(input logic [127:0] pt, input logic [127:0] key,
                                  output logic [127:0] ct, output logic [127:0] klast);
    logic [7:0] s[16], k[16], t[16], rc;
    for (int i = 0; i < 16; i++) begin
      s[i] = pt[127-8*i -: 8];
      k[i] = key[127-8*i -: 8];
      s[i] = s[i] ^ k[i];
    end
    rc = 8'h01;
    for (int r = 1; r <= 10; r++) begin
      k[0] = k[0] ^ ref_sb[k[13]] ^ rc;
      k[1] = k[1] ^ ref_sb[k[14]];
      k[2] = k[2] ^ ref_sb[k[15]];
      k[3] = k[3] ^ ref_sb[k[12]];
      for (int i = 4; i < 16; i++) k[i] = k[i] ^ k[i-4];
      rc = m_xt(rc);
      for (int c = 0; c < 4; c++)
        for (int w = 0; w < 4; w++) t[c*4+w] = ref_sb[s[((c+w)%4)*4+w]];
      for (int c = 0; c < 4; c++) begin
        logic [7:0] a0, a1, a2, a3;
        a0 = t[c*4]; a1 = t[c*4+1]; a2 = t[c*4+2]; a3 = t[c*4+3];
        if (r < 10) begin
          t[c*4]   = m_xt(a0 ^ a1) ^ a1 ^ a2 ^ a3;
          t[c*4+1] = m_xt(a1 ^ a2) ^ a2 ^ a3 ^ a0;
          t[c*4+2] = m_xt(a2 ^ a3) ^ a3 ^ a0 ^ a1;
          t[c*4+3] = m_xt(a3 ^ a0) ^ a0 ^ a1 ^ a2;
        end
      end
      for (int i = 0; i < 16; i++) s[i] = t[i] ^ k[i];
    end
    for (int i = 0; i < 16; i++) begin
      ct[127-8*i -: 8]    = s[i];
      klast[127-8*i -: 8] = k[i];
    end
  endfunction

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #1 d = rdata;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic load_blk(input logic [1:0] a, input logic [127:0] v);
    logic [7:0] dummy;
    bus_rd(A_CTRL, dummy);
    for (int i = 0; i < 16; i++) bus_wr(a, v[127-8*i -: 8]);
  endtask

  task automatic read_blk(input logic [1:0] a, output logic [127:0] v);
    logic [7:0] b;
    bus_rd(A_CTRL, b);
    for (int i = 0; i < 16; i++) begin
      bus_rd(a, b);
      v[127-8*i -: 8] = b;
    end
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (!done_evt && n < 40) begin
      @(negedge clk);
      n++;
    end
    chk(done_evt, tag, 128'(n), 128'd11);
  endtask

  localparam logic [127:0] FK  = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [127:0] FPT = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] FCT = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] FKL = 128'h13111d7fe3944a17f307a78b4d2b30c5;

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]   b, v[17];
    logic [127:0] blk, ct, kl, key, pt;
    n_tests = 0; n_fail = 0;
    addr = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
    rst_ni = 1'b0;
    void'($urandom(32'h5eed_a11e));
    build_sbox();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    bus_rd(A_STAT, b);
    chk(b == 8'h00, "R1 status after reset", 128'(b), 128'h0);
    chk(!busy && !done_evt, "R1 busy/done_evt after reset", {busy, done_evt}, 128'h0);

    // R12: control readback of direction
    bus_wr(A_CTRL, 8'h02);
    bus_rd(A_CTRL, b);
    chk(b == 8'h02, "R12 control direction bit", 128'(b), 128'h2);
    bus_wr(A_CTRL, 8'h00);

    // R2: block pointer increments and wraps
    for (int i = 0; i < 17; i++) v[i] = 8'($urandom());
    blk = '0;
    for (int i = 0; i < 16; i++) blk[127-8*i -: 8] = v[i];
    load_blk(A_DATA, blk);
    read_blk(A_DATA, ct);
    chk(ct == blk, "R2 block readback", ct, blk);
    bus_wr(A_DATA, v[16]);
    bus_rd(A_CTRL, b);
    bus_rd(A_DATA, b);
    chk(b == v[16], "R2 wrap overwrites byte 0", 128'(b), 128'(v[16]));
    bus_rd(A_DATA, b);
    chk(b == v[1], "R2 byte 1 kept after wrap", 128'(b), 128'(v[1]));

    // R3: independent key pointers
    bus_rd(A_CTRL, b);
    for (int i = 0; i < 4; i++) bus_wr(A_KEY, 8'hc0 + 8'(i));
    bus_rd(A_KEY, b);
    chk(b == 8'hc0, "R3 key read ptr independent (byte0)", 128'(b), 128'hc0);
    bus_rd(A_KEY, b);
    chk(b == 8'hc1, "R3 key read ptr independent (byte1)", 128'(b), 128'hc1);
    // R4: control access rewinds the key read pointer
    bus_rd(A_CTRL, b);
    bus_rd(A_KEY, b);
    chk(b == 8'hc0, "R4 control access rewinds pointers", 128'(b), 128'hc0);

    // reference model sanity against the published vector
    ref_enc(FPT, FK, ct, kl);
    chk(ct == FCT && kl == FKL, "R6 bench model vector", ct, FCT);

    // R5: key readback before processing
    load_blk(A_KEY, FK);
    load_blk(A_DATA, FPT);
    read_blk(A_KEY, kl);
    chk(kl == FK, "R5 key readback before run", kl, FK);

    // R6/R9: timed encryption
    bus_wr(A_CTRL, 8'h01);
    @(negedge clk);
    chk(busy && !done_evt, "R9 busy after start", {busy, done_evt}, 128'h2);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(busy && !done_evt, "R9 busy during rounds", {busy, done_evt}, 128'h2);
    end
    @(negedge clk);
    chk(!busy && done_evt, "R6 done_evt 11 cycles after start", {busy, done_evt}, 128'h1);
    @(negedge clk);
    chk(!done_evt, "R9 done_evt single cycle", 128'(done_evt), 128'h0);
    read_blk(A_DATA, ct);
    chk(ct == FCT, "R6 ciphertext", ct, FCT);
    read_blk(A_KEY, kl);
    chk(kl == FKL, "R7 final round key left in key memory", kl, FKL);
    bus_rd(A_STAT, b);
    chk(b == 8'h01, "R11 done set after run", 128'(b), 128'h1);
    bus_wr(A_STAT, 8'h00);
    bus_rd(A_STAT, b);
    chk(b == 8'h01, "R11 write 0 keeps done", 128'(b), 128'h1);
    bus_wr(A_STAT, 8'h01);
    bus_rd(A_STAT, b);
    chk(b == 8'h00, "R11 write 1 clears done", 128'(b), 128'h0);

    // R8: decryption from loaded final round key
    bus_wr(A_STAT, 8'h01);
    load_blk(A_KEY, FKL);
    load_blk(A_DATA, FCT);
    bus_wr(A_CTRL, 8'h03);
    bus_rd(A_STAT, b);
    chk(b == 8'h02, "R12 status busy, R11 start clears done", 128'(b), 128'h2);
    wait_done("R8 decrypt completes");
    read_blk(A_DATA, pt);
    chk(pt == FPT, "R8 plaintext recovered", pt, FPT);
    read_blk(A_KEY, kl);
    chk(kl == FK, "R8 cipher key regenerated", kl, FK);

    // R10: writes during busy are ignored
    load_blk(A_KEY, FK);
    load_blk(A_DATA, FPT);
    bus_wr(A_CTRL, 8'h01);
    bus_wr(A_DATA, 8'haa);
    bus_wr(A_KEY, 8'h55);
    bus_wr(A_DATA, 8'hbb);
    wait_done("R10 run completes");
    @(negedge clk);
    bus_wr(A_DATA, 8'h77);
    read_blk(A_DATA, ct);
    chk(ct == {8'h77, FCT[119:0]}, "R10 busy writes ignored, data pointer unmoved", ct, {8'h77, FCT[119:0]});
    read_blk(A_KEY, kl);
    chk(kl == FKL, "R10 key untouched by busy write", kl, FKL);

    // random round trips: encrypt, then decrypt in place
    for (int it = 0; it < 6; it++) begin
      logic [127:0] ect, ekl;
      key = {$urandom(), $urandom(), $urandom(), $urandom()};
      pt  = {$urandom(), $urandom(), $urandom(), $urandom()};
      if (it == 0) key = '0;
      if (it == 1) pt  = '1;
      ref_enc(pt, key, ect, ekl);
      load_blk(A_KEY, key);
      load_blk(A_DATA, pt);
      bus_wr(A_CTRL, 8'h01);
      wait_done("R6 random encrypt completes");
      read_blk(A_DATA, ct);
      chk(ct == ect, "R6 random ciphertext", ct, ect);
      read_blk(A_KEY, kl);
      chk(kl == ekl, "R7 random final round key", kl, ekl);
      bus_wr(A_CTRL, 8'h03);
      wait_done("R8 random decrypt completes");
      read_blk(A_DATA, blk);
      chk(blk == pt, "R8 random plaintext", blk, pt);
      read_blk(A_KEY, kl);
      chk(kl == key, "R8 random key regenerated", kl, key);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule